// File: doc/BRIEF.md
# Every-third-one detector

This block watches a one-bit input stream that is sampled on every rising clock edge. It counts the 1s it sees and ignores the 0s. On the third 1 since the last report, it raises a pulse output in the same cycle as that 1. The 1s do not need to be adjacent. After the pulse, counting starts again from zero, so the output marks every third 1 in the stream. Typical uses are thinning a stream of event strobes by three, or giving a carry to a chained counter.

The count is kept in a two-bit register that holds the number of 1s pending: zero, one or two. The output is a Mealy function of that register and the current input, so it has no register of its own. A parameter picks how the register is built. One option is a pair of JK-style cells with the classic excitation equations. The other is a plain D register fed by a case table. Both options give the same behaviour at the ports.

Top module: `third_one_detector`

## Requirements
- R1: The internal count only takes the codes 00 (no 1s pending), 01 (one pending) and 10 (two pending). Code 11 never occurs after reset.
- R2: In a cycle where `in_bit` is 0, `third_pulse` is 0 and the pending count is unchanged.
- R3: In a cycle where `in_bit` is 1 and fewer than two 1s are pending, `third_pulse` is 0 and the pending count rises by one at the next edge.
- R4: In a cycle where `in_bit` is 1 and two 1s are pending, `third_pulse` is 1 in that cycle and the pending count returns to zero at the next edge.
- R5: `third_pulse` follows `in_bit` within the same cycle with no clock edge in between. Raising or lowering `in_bit` while two 1s are pending raises or lowers the output at once.
- R6: A synchronous reset (`srst` high at a rising edge) clears the pending count to zero, whatever `in_bit` is. While the count is zero, `third_pulse` stays 0.
- R7: The JK-cell build (`FF_KIND` = 0) and the D-register build (`FF_KIND` = 1) produce identical `third_pulse` sequences for any stimulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| srst | input | 1 | Synchronous active-high reset |
| in_bit | input | 1 | Sampled input stream |
| third_pulse | output | 1 | High in the cycle that carries the third pending 1 |

## Verification
The checker takes for granted that reset is applied at the first clock edge, so that the count register starts at a legal code. It also assumes that `in_bit` settles well before each rising edge, because the Mealy output is checked against that settled value. The stimulus drives `in_bit` and `srst` only on the falling edge, and holds reset for the first cycles. It then mixes runs of adjacent 1s, 1s separated by long gaps of 0s, and resets applied part-way through a count. A pseudo-random phase follows. The code 11 cannot be forced from the ports, so its recovery path is left to the design notes.

// File: rtl/third_one_pkg.sv
package third_one_pkg;
   localparam int unsigned STATE_W = 2;
   typedef logic [STATE_W-1:0] cnt_t;
   localparam cnt_t CNT_ZERO = 2'b00;
   localparam cnt_t CNT_ONE  = 2'b01;
   localparam cnt_t CNT_TWO  = 2'b10;
   localparam cnt_t CNT_BAD  = 2'b11;
   localparam int unsigned KIND_JK = 0;
   localparam int unsigned KIND_D  = 1;
endpackage

// File: rtl/third_one_jk_bit.sv
module third_one_jk_bit (
   input  logic clk,
   input  logic srst,
   input  logic j,
   input  logic k,
   output logic q
);
   logic q_nxt;

   // hold, set, clear or toggle
   assign q_nxt = (j & ~q) | (~k & q);

   always_ff @(posedge clk) begin
      if (srst) q <= 1'b0;
      else      q <= q_nxt;
   end
endmodule

// File: rtl/third_one_state.sv
module third_one_state
   import third_one_pkg::*;
#(
   parameter int unsigned FF_KIND = KIND_JK
) (
   input  logic clk,
   input  logic srst,
   input  logic x,
   output cnt_t q
);
   generate
      if (FF_KIND == KIND_JK) begin : g_jk
         logic           bad;
         logic [STATE_W-1:0] jv;
         logic [STATE_W-1:0] kv;
         assign bad   = q[1] & q[0];
         assign jv[1] = q[0] & x;
         assign kv[1] = x | bad;
         assign jv[0] = ~q[1] & x;
         assign kv[0] = x | bad;
         for (genvar i = 0; i < STATE_W; i++) begin : g_bit
            third_one_jk_bit u_ff (
               .clk  (clk),
               .srst (srst),
               .j    (jv[i]),
               .k    (kv[i]),
               .q    (q[i])
            );
         end
      end else if (FF_KIND == KIND_D) begin : g_d
         cnt_t nxt;
         always_comb begin
            case (q)
               CNT_ZERO: nxt = x ? CNT_ONE  : CNT_ZERO;
               CNT_ONE:  nxt = x ? CNT_TWO  : CNT_ONE;
               CNT_TWO:  nxt = x ? CNT_ZERO : CNT_TWO;
               default:  nxt = CNT_ZERO;
            endcase
         end
         always_ff @(posedge clk) begin
            if (srst) q <= CNT_ZERO;
            else      q <= nxt;
         end
      end else begin : g_bad_kind
         $error("third_one_state: FF_KIND must be 0 (JK) or 1 (D)");
      end
   endgenerate
endmodule

// File: rtl/third_one_out.sv
module third_one_out
   import third_one_pkg::*;
(
   input  cnt_t q,
   input  logic x,
   output logic c
);
   // code 11 yields 0
   assign c = x & q[1] & ~q[0];
endmodule

// File: rtl/third_one_detector.sv
module third_one_detector
   import third_one_pkg::*;
#(
   parameter int unsigned FF_KIND = KIND_JK
) (
   input  logic clk,
   input  logic srst,
   input  logic in_bit,
   output logic third_pulse
);
   generate
      if (STATE_W != 2) begin : g_bad_width
         $error("third_one_detector: count register must be two bits");
      end
   endgenerate

   cnt_t cur_q;

   third_one_state #(.FF_KIND(FF_KIND)) u_state (
      .clk  (clk),
      .srst (srst),
      .x    (in_bit),
      .q    (cur_q)
   );

   third_one_out u_out (
      .q (cur_q),
      .x (in_bit),
      .c (third_pulse)
   );
endmodule

// File: rtl/third_one_checker.sv
module third_one_checker (
   input logic       clk,
   input logic       srst,
   input logic       in_bit,
   input logic       third_pulse,
   input logic [1:0] cnt
);
   p_legal_code_r1: assert property (@(posedge clk) disable iff (srst)
      cnt != 2'b11);

   p_hold_on_zero_r2: assert property (@(posedge clk) disable iff (srst)
      (!in_bit && cnt != 2'b11) |=> $stable(cnt));

   p_quiet_on_zero_r2: assert property (@(posedge clk) disable iff (srst)
      !in_bit |-> !third_pulse);

   p_step_from_zero_r3: assert property (@(posedge clk) disable iff (srst)
      (in_bit && cnt == 2'b00) |=> cnt == 2'b01);

   p_step_from_one_r3: assert property (@(posedge clk) disable iff (srst)
      (in_bit && cnt == 2'b01) |=> cnt == 2'b10);

   p_pulse_on_third_r4: assert property (@(posedge clk) disable iff (srst)
      (in_bit && cnt == 2'b10) |-> third_pulse);

   p_wrap_after_third_r4: assert property (@(posedge clk) disable iff (srst)
      (in_bit && cnt == 2'b10) |=> cnt == 2'b00);

   p_pulse_needs_two_r5: assert property (@(posedge clk) disable iff (srst)
      third_pulse |-> (in_bit && cnt == 2'b10));

   p_reset_clears_r6: assert property (@(posedge clk)
      srst |=> cnt == 2'b00);
endmodule

bind third_one_detector third_one_checker u_chk (
   .clk         (clk),
   .srst        (srst),
   .in_bit      (in_bit),
   .third_pulse (third_pulse),
   .cnt         (cur_q)
);

// File: tb/third_one_detector_bench.sv
`timescale 1ns/1ps
module third_one_detector_bench;
   logic clk = 1'b0;
   logic srst = 1'b1;
   logic in_bit = 1'b0;
   logic pulse_jk;
   logic pulse_d;

   int checks = 0;
   int failures = 0;
   int pending = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   third_one_detector #(.FF_KIND(0)) u_third_one_detector (
      .clk(clk), .srst(srst), .in_bit(in_bit), .third_pulse(pulse_jk));

   third_one_detector #(.FF_KIND(1)) u_third_one_detector_d (
      .clk(clk), .srst(srst), .in_bit(in_bit), .third_pulse(pulse_d));

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   // one cycle: drive at falling edge, check the Mealy output, advance the model
   task automatic step(input logic xv, input logic rv);
      logic  exp;
      string req;
      @(negedge clk);
      in_bit = xv;
      srst   = rv;
      #1;
      exp = xv && (pending == 2);
      if (rv && pending == 0) req = "R6";
      else if (!xv)           req = "R2";
      else if (pending < 2)   req = "R3";
      else                    req = "R4";
      check(req, pulse_jk, exp);
      check("R7", pulse_d, pulse_jk);
      if (rv)       pending = 0;
      else if (xv)  pending = (pending + 1) % 3;
   endtask

   initial begin
      // watchdog
      #2_000_000;
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int unsigned lfsr = 32'h1d2c_3b4a;
      // R6: reset state, with in_bit both low and high during reset
      step(1'b0, 1'b1);
      step(1'b1, 1'b1);
      step(1'b1, 1'b1);
      step(1'b0, 1'b0);
      // adjacent ones: pulse on every third (R3, R4)
      for (int i = 0; i < 9; i++) step(1'b1, 1'b0);
      // ones spread by gaps of zeros (R2 hold)
      for (int i = 0; i < 6; i++) begin
         step(1'b1, 1'b0);
         for (int g = 0; g < i + 1; g++) step(1'b0, 1'b0);
      end
      // R5: output follows input within one cycle while two are pending
      step(1'b1, 1'b0);
      step(1'b1, 1'b0);
      @(negedge clk);
      in_bit = 1'b0;
      #1 check("R5", pulse_jk, 1'b0);
      #1 in_bit = 1'b1;
      #1 check("R5", pulse_jk, 1'b1);
      #1 in_bit = 1'b0;
      #1 check("R5", pulse_jk, 1'b0);
      check("R7", pulse_d, pulse_jk);
      // that cycle ends with in_bit low, so two still pending
      step(1'b1, 1'b0);
      // R6: reset part-way through a count discards the pending ones
      step(1'b1, 1'b0);
      step(1'b1, 1'b0);
      step(1'b1, 1'b1);
      step(1'b1, 1'b0);
      step(1'b1, 1'b0);
      step(1'b1, 1'b0);
      // pseudo-random phase
      for (int n = 0; n < 3000; n++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         step(lfsr[3], (lfsr[15:9] == 7'd0));
      end
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule